// File: doc/BRIEF.md
# Mode Register Load Controller

This block sits beside a memory command path. It watches each command that reaches the device and acts on mode-register loads. A load is accepted only when it is addressed to the base mode register, when every bank is idle, when no burst is running, and when the previous load's settling time has run out. An accepted load stores the 13-bit word. The block then gives the burst length in beats, the burst ordering and the read latency in half-clock units, all decoded from that word. The last accepted setting stays until another load replaces it or until reset.

The operating-mode field accepts two values: normal operation, and a request to reset the delay-locked loop. The reset request produces a single-cycle `dll_reset` pulse, and its bit is stored as zero, so the request clears itself. Three error pulses report rejected loads: a load issued while the array is busy, a load with a reserved operating mode, and any command issued during the settling window. A sticky warning is raised when a reset request is followed by an ordinary command before a load that restores normal mode.

Top module: `modereg_load_ctrl`

## Requirements
- R1: A load (`cmd_valid` and `cmd_load` high) is acted on only when `cmd_bank` is 0; a load with any other bank value changes no output.
- R2: Burst code A[2:0] = 1, 2, 3 gives `burst_beats` 2, 4, 8, and any other code gives 0. A[3] = 1 means interleaved ordering. Latency code A[6:4] = 2 gives `cas_half_clk` 4 and code 6 gives 5, and any other code gives 0. All of these are decoded from the stored word.
- R3: `mode_word` and the fields decoded from it change only on an accepted load. An accepted load updates them at the clock edge that samples the command.
- R4: An accepted load with A[12:7] = 6'b000010 sets `dll_reset` high for exactly the cycle after the sampling edge, and stores bit 8 as 0.
- R5: A base load issued while any `banks_idle` bit is 0 or while `burst_active` is 1 is ignored, and `err_illegal` pulses for one cycle.
- R6: A base load that is otherwise legal and has A[12:7] other than 0 or 6'b000010 is ignored, and `err_reserved` pulses for one cycle.
- R7: After an accepted load, `ready` is low for exactly WAIT_CYCLES cycles. After that it is high again.
- R8: Any command presented while `ready` is low is ignored, and `cmd_reject` pulses for one cycle.
- R9: After a reset-request load, if an accepted non-load command (`cmd_load` = 0) arrives before a normal-mode load, `dll_seq_warn` goes high. It stays high until the next accepted normal-mode load.
- R10: After reset, `mode_word` is 0, `ready` is 1, and every pulse and the warning are 0.
- R11: In any cycle at most one error pulse is high. Rejection during the wait takes precedence over the busy error, and the busy error takes precedence over the reserved-mode error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_load | input | 1 | The presented command is a mode-register load |
| cmd_bank | input | 2 | Bank address of the command |
| cmd_addr | input | 13 | Address word carrying the mode fields |
| banks_idle | input | NUM_BANKS | One bit per bank, 1 when that bank is idle |
| burst_active | input | 1 | A read or write burst is in progress |
| ready | output | 1 | High when a new command may be issued |
| mode_word | output | 13 | Stored mode word, bit 8 always 0 |
| burst_beats | output | 4 | Decoded burst length in beats, 0 if reserved |
| burst_interleaved | output | 1 | 1 for interleaved ordering |
| cas_half_clk | output | 3 | Read latency in half clocks, 0 if reserved |
| dll_reset | output | 1 | One-cycle pulse on an accepted reset-request load |
| dll_seq_warn | output | 1 | Sticky warning: reset request not followed by a normal-mode load |
| err_illegal | output | 1 | Pulse: load refused because the array was busy |
| err_reserved | output | 1 | Pulse: load refused for a reserved operating mode |
| cmd_reject | output | 1 | Pulse: command refused during the settling wait |

## Verification
The hardest states to reach from the ports are those where several refusal causes hold at once. One example is a busy-array load that also carries a reserved mode. Another is a load, or an ordinary command, that falls inside the settling window right after a reset request. These states decide both the priority between the error pulses and whether the warning can be triggered by a command that was refused. The stimulus reaches them with directed back-to-back sequences. It then runs a long random phase in which commands arrive most cycles, the idle and burst inputs toggle, and the operating-mode bits favour the normal, reset-request and reserved patterns. A behavioural model is compared with every output on every clock.

// File: rtl/modereg_pkg.sv
// Package: shared widths, field positions and the operating-mode class
// for the mode register load controller.
package modereg_pkg;

    localparam int MR_W      = 13;  // width of the mode word
    localparam int BANK_W    = 2;   // width of the bank address
    localparam int BL_LSB    = 0;   // burst-length field
    localparam int BL_W      = 3;
    localparam int BT_BIT    = 3;   // burst-ordering bit
    localparam int CL_LSB    = 4;   // read-latency field
    localparam int CL_W      = 3;
    localparam int OPM_LSB   = 7;   // operating-mode field
    localparam int OPM_W     = 6;
    localparam int DLL_BIT   = 8;   // self-clearing reset-request bit

    // Operating-mode pattern that requests a DLL reset (A8 only)
    localparam logic [OPM_W-1:0] OPM_DLL_PATTERN = 6'b000010;

    typedef enum logic [1:0] {
        OPM_NORMAL   = 2'd0,
        OPM_DLL_RST  = 2'd1,
        OPM_RESERVED = 2'd2
    } opmode_e;

    // Decoded view of one mode word
    typedef struct packed {
        logic [3:0] beats;
        logic       interleaved;
        logic [2:0] cas_half;
        opmode_e    opmode;
    } mr_fields_t;

endpackage

// File: rtl/mr_field_decode.sv
// Module: mr_field_decode
// Purely combinational decode of a 13-bit mode word into burst length in
// beats, burst ordering, read latency in half clocks, and operating-mode
// class. Assumes the field positions defined in modereg_pkg. Reserved
// burst or latency codes decode to zero.
module mr_field_decode
    import modereg_pkg::*;
(
    input  logic [MR_W-1:0] word,
    output mr_fields_t      fields
);

    logic [BL_W-1:0]  bl_code;
    logic [CL_W-1:0]  cl_code;
    logic [OPM_W-1:0] opm_code;

    assign bl_code  = word[BL_LSB +: BL_W];
    assign cl_code  = word[CL_LSB +: CL_W];
    assign opm_code = word[OPM_LSB +: OPM_W];

    // Map each field code to its decoded value
    always_comb begin
        fields.interleaved = word[BT_BIT];
        unique case (bl_code)
            3'd1:    fields.beats = 4'd2;
            3'd2:    fields.beats = 4'd4;
            3'd3:    fields.beats = 4'd8;
            default: fields.beats = 4'd0;
        endcase
        unique case (cl_code)
            3'd2:    fields.cas_half = 3'd4;
            3'd6:    fields.cas_half = 3'd5;
            default: fields.cas_half = 3'd0;
        endcase
        if (opm_code == '0)
            fields.opmode = OPM_NORMAL;
        else if (opm_code == OPM_DLL_PATTERN)
            fields.opmode = OPM_DLL_RST;
        else
            fields.opmode = OPM_RESERVED;
    end

endmodule

// File: rtl/mr_wait_timer.sv
// Module: mr_wait_timer
// Counts down the settling time after an accepted load. `busy` is high
// for exactly WAIT_CYCLES cycles following the edge that samples `start`.
// Assumes `start` never arrives while busy (the top refuses it).
// WAIT_CYCLES = 0 builds no counter.
module mr_wait_timer #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    generate
        if (WAIT_CYCLES == 0) begin : g_nowait
            assign busy = 1'b0;
        end else begin : g_count
            localparam int CW = $clog2(WAIT_CYCLES + 1);
            logic [CW-1:0] remain_q;

            // Load on start, otherwise count down to zero
            always_ff @(posedge clk) begin
                if (!rst_n)
                    remain_q <= '0;
                else if (start)
                    remain_q <= CW'(WAIT_CYCLES);
                else if (remain_q != '0)
                    remain_q <= remain_q - 1'b1;
            end

            assign busy = (remain_q != '0);
        end
    endgenerate

endmodule

// File: rtl/mr_dll_tracker.sv
// Module: mr_dll_tracker
// Produces the one-cycle DLL-reset pulse and tracks whether a reset
// request has been followed by a normal-mode load before the next
// ordinary command. The inputs are single-cycle and mutually exclusive
// accept strobes from the top.
module mr_dll_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_dll,     // accepted reset-request load
    input  logic acc_normal,  // accepted normal-mode load
    input  logic acc_other,   // accepted non-load command
    output logic dll_pulse,
    output logic seq_warn
);

    logic pending_q;

    // One-cycle pulse: the request bit is never held
    always_ff @(posedge clk) begin
        if (!rst_n)
            dll_pulse <= 1'b0;
        else
            dll_pulse <= acc_dll;
    end

    // Remember a reset request until a normal load or an ordinary command
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (acc_dll)
            pending_q <= 1'b1;
        else if (acc_normal || acc_other)
            pending_q <= 1'b0;
    end

    // Sticky warning, cleared only by a normal-mode load
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_warn <= 1'b0;
        else if (acc_normal)
            seq_warn <= 1'b0;
        else if (acc_other && pending_q)
            seq_warn <= 1'b1;
    end

endmodule

// File: rtl/modereg_load_ctrl.sv
// Module: modereg_load_ctrl
// Qualifies mode-register loads against bank selection, array activity,
// reserved operating modes and the post-load settling window. It stores
// the accepted word with the reset-request bit cleared and decodes it.
// Assumes the command inputs are synchronous to clk and hold for one
// cycle per command.
module modereg_load_ctrl
    import modereg_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int WAIT_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_load,
    input  logic [1:0]           cmd_bank,
    input  logic [12:0]          cmd_addr,
    input  logic [NUM_BANKS-1:0] banks_idle,
    input  logic                 burst_active,
    output logic                 ready,
    output logic [12:0]          mode_word,
    output logic [3:0]           burst_beats,
    output logic                 burst_interleaved,
    output logic [2:0]           cas_half_clk,
    output logic                 dll_reset,
    output logic                 dll_seq_warn,
    output logic                 err_illegal,
    output logic                 err_reserved,
    output logic                 cmd_reject
);

    localparam logic [MR_W-1:0] DLL_CLEAR_MASK = ~(MR_W'(1) << DLL_BIT);

    mr_fields_t   in_fields;
    mr_fields_t   st_fields;
    logic [MR_W-1:0] word_q;
    logic         wait_busy;
    logic         base_load;
    logic         array_quiet;
    logic         refuse_wait;
    logic         refuse_busy;
    logic         refuse_resv;
    logic         accept_load;
    logic         accept_other;

    // Decode of the incoming address (operating-mode class only is used)
    mr_field_decode u_dec_in (
        .word   (cmd_addr),
        .fields (in_fields)
    );

    // Decode of the stored word for the outputs
    mr_field_decode u_dec_st (
        .word   (word_q),
        .fields (st_fields)
    );

    // Classify the command presented this cycle
    always_comb begin
        base_load    = cmd_valid && cmd_load && (cmd_bank == '0);
        array_quiet  = (&banks_idle) && !burst_active;
        refuse_wait  = cmd_valid && wait_busy;
        refuse_busy  = !refuse_wait && base_load && !array_quiet;
        refuse_resv  = !refuse_wait && base_load && array_quiet
                       && (in_fields.opmode == OPM_RESERVED);
        accept_load  = !refuse_wait && base_load && array_quiet
                       && (in_fields.opmode != OPM_RESERVED);
        accept_other = !wait_busy && cmd_valid && !cmd_load;
    end

    // Store an accepted word, reset-request bit forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (accept_load)
            word_q <= cmd_addr & DLL_CLEAR_MASK;
    end

    // Register the three refusal pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_reject   <= 1'b0;
            err_illegal  <= 1'b0;
            err_reserved <= 1'b0;
        end else begin
            cmd_reject   <= refuse_wait;
            err_illegal  <= refuse_busy;
            err_reserved <= refuse_resv;
        end
    end

    mr_wait_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept_load),
        .busy  (wait_busy)
    );

    mr_dll_tracker u_dll (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_dll    (accept_load && (in_fields.opmode == OPM_DLL_RST)),
        .acc_normal (accept_load && (in_fields.opmode == OPM_NORMAL)),
        .acc_other  (accept_other),
        .dll_pulse  (dll_reset),
        .seq_warn   (dll_seq_warn)
    );

    assign ready             = !wait_busy;
    assign mode_word         = word_q;
    assign burst_beats       = st_fields.beats;
    assign burst_interleaved = st_fields.interleaved;
    assign cas_half_clk      = st_fields.cas_half;

endmodule

// File: rtl/modereg_load_ctrl_chk.sv
// Module: modereg_load_ctrl_chk
// Assertion checker bound to modereg_load_ctrl; observes ports only.
module modereg_load_ctrl_chk #(
    parameter int NUM_BANKS   = 4,
    parameter int WAIT_CYCLES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_load,
    input logic [1:0]           cmd_bank,
    input logic [NUM_BANKS-1:0] banks_idle,
    input logic                 burst_active,
    input logic                 ready,
    input logic [12:0]          mode_word,
    input logic                 dll_reset,
    input logic                 dll_seq_warn,
    input logic                 err_illegal,
    input logic                 err_reserved,
    input logic                 cmd_reject
);

    // R8
    wait_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !ready) |=> (cmd_reject && $stable(mode_word)));

    // R5
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_load && cmd_bank == 2'd0 && ready
         && (!(&banks_idle) || burst_active))
        |=> (err_illegal && $stable(mode_word)));

    // R1
    bank_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_load && cmd_bank != 2'd0) |=> $stable(mode_word));

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_load) |=> $stable(mode_word));

    // R4
    dll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset |=> !dll_reset);

    // R7
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_reset && WAIT_CYCLES > 0) |-> !ready);

    // R11
    err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_illegal, err_reserved, cmd_reject}));

    // R9
    warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_seq_warn && !(cmd_valid && cmd_load)) |=> dll_seq_warn);

endmodule

bind modereg_load_ctrl modereg_load_ctrl_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_load     (cmd_load),
    .cmd_bank     (cmd_bank),
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .ready        (ready),
    .mode_word    (mode_word),
    .dll_reset    (dll_reset),
    .dll_seq_warn (dll_seq_warn),
    .err_illegal  (err_illegal),
    .err_reserved (err_reserved),
    .cmd_reject   (cmd_reject)
);

// File: tb/test_modereg_load_ctrl.sv
// Bench: drives directed and random commands. A behavioural model
// updated at each rising edge is compared with every output at each
// falling edge.
module test_modereg_load_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int WAITC      = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_load = 1'b0;
    logic [1:0]    cmd_bank = '0;
    logic [12:0]   cmd_addr = '0;
    logic [NB-1:0] banks_idle = '1;
    logic          burst_active = 1'b0;
    logic          ready;
    logic [12:0]   mode_word;
    logic [3:0]    burst_beats;
    logic          burst_interleaved;
    logic [2:0]    cas_half_clk;
    logic          dll_reset;
    logic          dll_seq_warn;
    logic          err_illegal;
    logic          err_reserved;
    logic          cmd_reject;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    int m_word = 0, m_wait = 0, m_pend = 0, m_warn = 0;
    int m_dll = 0, m_ill = 0, m_res = 0, m_rej = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modereg_load_ctrl #(.NUM_BANKS(NB), .WAIT_CYCLES(WAITC)) i_modereg_load_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_load(cmd_load),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .banks_idle(banks_idle),
        .burst_active(burst_active), .ready(ready), .mode_word(mode_word),
        .burst_beats(burst_beats), .burst_interleaved(burst_interleaved),
        .cas_half_clk(cas_half_clk), .dll_reset(dll_reset),
        .dll_seq_warn(dll_seq_warn), .err_illegal(err_illegal),
        .err_reserved(err_reserved), .cmd_reject(cmd_reject)
    );

    function automatic int beats_of(int w);
        case (w & 7)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int cas_of(int w);
        case ((w >> 4) & 7)
            2: return 4;
            6: return 5;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: next state from the inputs at each rising edge
    always @(posedge clk) begin
        int busy_now;
        int opm;
        if (!rst_n) begin
            m_word = 0; m_wait = 0; m_pend = 0; m_warn = 0;
            m_dll = 0; m_ill = 0; m_res = 0; m_rej = 0;
        end else begin
            busy_now = (m_wait != 0);
            m_dll = 0; m_ill = 0; m_res = 0; m_rej = 0;
            if (m_wait > 0) m_wait--;
            opm = (int'(cmd_addr) >> 7) & 63;
            if (cmd_valid) begin
                if (busy_now) m_rej = 1;
                else if (cmd_load) begin
                    if (cmd_bank == 0) begin
                        if (!(&banks_idle) || burst_active) m_ill = 1;
                        else if (opm != 0 && opm != 2) m_res = 1;
                        else begin
                            m_word = int'(cmd_addr) & ~(1 << 8);
                            m_wait = WAITC;
                            if (opm == 2) begin m_dll = 1; m_pend = 1; end
                            else begin m_pend = 0; m_warn = 0; end
                        end
                    end
                end else begin
                    if (m_pend) m_warn = 1;
                    m_pend = 0;
                end
            end
        end
    end

    // Compare every output at each falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3", "mode_word", int'(mode_word), m_word);
            check("R2", "burst_beats", int'(burst_beats), beats_of(m_word));
            check("R2", "burst_interleaved", int'(burst_interleaved), (m_word >> 3) & 1);
            check("R2", "cas_half_clk", int'(cas_half_clk), cas_of(m_word));
            check("R4", "dll_reset", int'(dll_reset), m_dll);
            check("R5", "err_illegal", int'(err_illegal), m_ill);
            check("R6", "err_reserved", int'(err_reserved), m_res);
            check("R8", "cmd_reject", int'(cmd_reject), m_rej);
            check("R7", "ready", int'(ready), (m_wait == 0) ? 1 : 0);
            check("R9", "dll_seq_warn", int'(dll_seq_warn), m_warn);
        end
    end

    task automatic drive(input bit v, input bit ld, input int ba, input int addr,
                         input int idle, input bit bur);
        @(negedge clk);
        cmd_valid = v; cmd_load = ld; cmd_bank = 2'(ba);
        cmd_addr = 13'(addr); banks_idle = NB'(idle); burst_active = bur;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 15, 0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL R7 watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "reset mode_word", int'(mode_word), 0);
        check("R10", "reset ready", int'(ready), 1);
        check("R10", "reset flags", int'({dll_reset, dll_seq_warn, err_illegal, err_reserved, cmd_reject}), 0);

        // normal load: BL 4, sequential, latency 2
        drive(1, 1, 0, 13'h022, 15, 0);
        nop(1);
        check("R7", "ready low after load", int'(ready), 0);
        nop(3);
        check("R2", "beats after load", int'(burst_beats), 4);

        // R1: other bank value ignored
        drive(1, 1, 1, 13'h003, 15, 0);
        nop(1);
        check("R1", "bank 1 load ignored", int'(mode_word), 13'h022);

        // busy array and active burst
        drive(1, 1, 0, 13'h013, 7, 0);
        drive(1, 1, 0, 13'h013, 15, 1);
        nop(2);
        // reserved mode, and busy plus reserved together (R11: busy wins)
        drive(1, 1, 0, 13'h0A2, 15, 0);
        drive(1, 1, 0, 13'h0A2, 14, 0);
        nop(1);
        check("R11", "busy beats reserved", int'({err_illegal, err_reserved}), 2);

        // reset request load then a load inside the wait (R11: reject wins)
        drive(1, 1, 0, 13'h16B, 15, 0);
        drive(1, 1, 0, 13'h0A2, 14, 0);
        nop(1);
        check("R11", "reject beats busy", int'({cmd_reject, err_illegal}), 2);
        check("R4", "request bit cleared", int'(mode_word), 13'h06B);
        check("R2", "latency 2.5", int'(cas_half_clk), 5);
        nop(2);
        // ordinary command triggers the warning
        drive(1, 0, 2, 13'h000, 15, 0);
        nop(1);
        check("R9", "warning raised", int'(dll_seq_warn), 1);
        nop(2);
        check("R9", "warning held", int'(dll_seq_warn), 1);
        drive(1, 1, 0, 13'h031, 15, 0);
        nop(3);
        check("R9", "warning cleared", int'(dll_seq_warn), 0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int opsel;
            int addr;
            opsel = $urandom_range(0, 5);
            addr = $urandom_range(0, 127);
            if (opsel == 1) addr |= 13'h100;
            else if (opsel == 2) addr |= ($urandom_range(1, 63) << 7);
            drive($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
                  ($urandom_range(0, 5) == 0) ? $urandom_range(1, 3) : 0, addr,
                  ($urandom_range(0, 4) == 0) ? $urandom_range(0, 14) : 15,
                  $urandom_range(0, 5) == 0);
        end
        nop(4);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule